// File: doc/BRIEF.md
# Synchronous Burst Flash Read Controller

This block sits between a host read port and a NOR-style flash that takes its start address on a single strobe and returns data in synchronous linear bursts. The host hands over a start address and a word count. The controller then runs the flash through a fixed sequence. It selects the chip first. It pulses the address strobe for one clock while it drives the address. It enables the flash outputs and lets a programmable number of initial wait clocks pass. After that it qualifies each incoming word with the flash ready line.

The ready line can run in one of two modes, chosen by a configuration input. In early mode the ready line leads the data by one clock, so the word is taken on the edge after ready is seen high. In aligned mode ready and data arrive together. While ready is low the burst stalls without losing count. If ready stays low for too long, a programmable miss limit ends the burst with an error pulse. Captured words leave on a registered valid/data stream, and the final word carries a last flag.

Top module: `sbf_rd_ctrl`

## Requirements
- R1: During and after a synchronous reset, fl_ce_n, fl_avd_n and fl_oe_n are high, req_ready is high, and rd_valid, rd_last and rd_err are low.
- R2: A request is taken on a rising edge where req_valid and req_ready are both high. req_ready is low from the next cycle until the burst has been torn down. req_valid asserted while req_ready is low has no effect.
- R3: After a request is taken, fl_ce_n goes low one cycle before fl_avd_n goes low. fl_avd_n is low for exactly one cycle per burst. fl_addr carries the request address from the cycle after acceptance and stays stable through the rise of fl_avd_n.
- R4: fl_oe_n goes low in the cycle after the address-strobe cycle. Data qualification then starts after cfg_wait further clocks, and the default setting of 6 is supported. A cfg_wait of 0 starts qualification immediately.
- R5: With cfg_rdy_early = 0, a word is captured on the rising edge at which fl_rdy is high, and it appears on rd_data with rd_valid in the following cycle.
- R6: With cfg_rdy_early = 1, a word is captured from fl_dq on the edge after the edge at which fl_rdy was seen high. This includes fl_rdy seen high in the last initial wait clock.
- R7: While fl_rdy does not qualify a word, no word is produced and the word count does not advance. The burst continues when fl_rdy returns.
- R8: A burst returns req_len + 1 words, from the start address and the addresses that follow it in order (wrapping modulo the address width). rd_last is high together with rd_valid on the final word only.
- R9: In the cycle after the final word is captured, fl_oe_n is high while fl_ce_n is still low. In the cycle after that, fl_ce_n and req_ready are high.
- R10: When the number of consecutive non-qualifying burst clocks reaches cfg_wdog_lim, the burst is aborted. A limit of 0 acts like 1. rd_err pulses high for one cycle with no rd_valid, and teardown follows as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the flash |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | WAIT_W | Initial wait clocks before qualification |
| cfg_rdy_early | input | 1 | 1: ready leads data by one clock; 0: ready aligned with data |
| cfg_wdog_lim | input | WD_W | Consecutive miss limit before abort |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Burst start word address |
| req_len | input | LEN_W | Burst length minus one |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_avd_n | output | 1 | Flash address strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq | input | DATA_W | Flash data bus |
| fl_rdy | input | 1 | Flash ready |
| rd_valid | output | 1 | Host data valid strobe |
| rd_data | output | DATA_W | Host data word |
| rd_last | output | 1 | Final word of the burst |
| rd_err | output | 1 | Burst aborted by the miss limit |

## Verification
A wrong sequencer state shows up at the strobe pins in the very next cycle, because each strobe is registered from the next state. An off-by-one in the wait timer or in the ready delay register shifts the capture point by one clock. The word taken is then the bus filler instead of the value computed from its address, so the first rd_valid after the wait already shows the fault. A corrupted word counter shows up as a missing or extra rd_last at the end of the burst. A miss counter that fails to clear on a qualified word shows up as a premature rd_err in the stalled-burst patterns.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR,
    ST_WAIT,
    ST_BURST,
    ST_TAIL
  } sbf_state_e;

endpackage

// File: rtl/sbf_wait_tmr.sv
// Initial-access wait timer: loaded with the wait count, counts down to 1.
module sbf_wait_tmr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              en,
  input  logic [WAIT_W-1:0] init,
  output logic              done
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= init;
    end else if (en && (cnt_q > WAIT_W'(1))) begin
      cnt_q <= cnt_q - WAIT_W'(1);
    end
  end

  assign done = (cnt_q <= WAIT_W'(1));

endmodule

// File: rtl/sbf_rdy_qual.sv
// Ready qualification (early or aligned) and consecutive-miss watchdog.
module sbf_rdy_qual #(
  parameter int WD_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            early,
  input  logic            track,
  input  logic            in_burst,
  input  logic            rdy,
  input  logic [WD_W-1:0] lim,
  output logic            hit,
  output logic            timeout
);

  logic            rdy_d1_q;
  logic [WD_W-1:0] miss_q;
  logic [WD_W:0]   miss_nxt;

  // Ready seen one clock ago; only meaningful once outputs are enabled.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_d1_q <= 1'b0;
    end else begin
      rdy_d1_q <= track & rdy;
    end
  end

  assign hit      = in_burst & (early ? rdy_d1_q : rdy);
  assign miss_nxt = {1'b0, miss_q} + (WD_W + 1)'(1);
  assign timeout  = in_burst & ~hit & (miss_nxt >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (rst || !in_burst || hit || timeout) begin
      miss_q <= '0;
    end else begin
      miss_q <= miss_q + WD_W'(1);
    end
  end

endmodule

// File: rtl/sbf_capture.sv
// Registered host-side output stage.
module sbf_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              last,
  input  logic              abort,
  input  logic [DATA_W-1:0] din,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              rd_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap;
      rd_last  <= cap & last;
      rd_err   <= abort;
      if (cap) begin
        rd_data <= din;
      end
    end
  end

endmodule

// File: rtl/sbf_fsm.sv
// Burst sequencer: strobe ordering, word count, teardown.
module sbf_fsm
  import sbf_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wait_zero,
  input  logic              tmr_done,
  input  logic              hit,
  input  logic              timeout,
  output sbf_state_e        state,
  output logic              tmr_load,
  output logic              last_word,
  output logic              ce_n,
  output logic              avd_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  sbf_state_e       st_q, nxt;
  logic [LEN_W-1:0] left_q;
  logic             accept;

  assign state     = st_q;
  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign tmr_load  = (st_q == ST_ADDR);
  assign last_word = (st_q == ST_BURST) && hit && (left_q == '0);

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid) nxt = ST_SETUP;
      ST_SETUP: nxt = ST_ADDR;
      ST_ADDR:  nxt = wait_zero ? ST_BURST : ST_WAIT;
      ST_WAIT:  if (tmr_done) nxt = ST_BURST;
      ST_BURST: if (last_word || timeout) nxt = ST_TAIL;
      ST_TAIL:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ce_n   <= 1'b1;
      avd_n  <= 1'b1;
      oe_n   <= 1'b1;
      ready  <= 1'b1;
      addr   <= '0;
      left_q <= '0;
    end else begin
      st_q  <= nxt;
      ce_n  <= (nxt == ST_IDLE);
      avd_n <= (nxt != ST_ADDR);
      oe_n  <= !((nxt == ST_WAIT) || (nxt == ST_BURST));
      ready <= (nxt == ST_IDLE);
      if (accept) begin
        addr   <= req_addr;
        left_q <= req_len;
      end else if ((st_q == ST_BURST) && hit && (left_q != '0)) begin
        left_q <= left_q - LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/sbf_rd_ctrl.sv
// Synchronous burst flash read controller, top level.
module sbf_rd_ctrl
  import sbf_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int WAIT_W = 4,
  parameter int WD_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_rdy_early,
  input  logic [WD_W-1:0]   cfg_wdog_lim,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              fl_ce_n,
  output logic              fl_avd_n,
  output logic              fl_oe_n,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic [DATA_W-1:0] fl_dq,
  input  logic              fl_rdy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              rd_err
);

  sbf_state_e state;
  logic       tmr_load, tmr_done, hit, timeout, last_word;
  logic       track, in_burst;

  assign track    = (state == ST_WAIT) || (state == ST_BURST);
  assign in_burst = (state == ST_BURST);

  sbf_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .wait_zero (cfg_wait == '0),
    .tmr_done  (tmr_done),
    .hit       (hit),
    .timeout   (timeout),
    .state     (state),
    .tmr_load  (tmr_load),
    .last_word (last_word),
    .ce_n      (fl_ce_n),
    .avd_n     (fl_avd_n),
    .oe_n      (fl_oe_n),
    .addr      (fl_addr),
    .ready     (req_ready)
  );

  sbf_wait_tmr #(.WAIT_W(WAIT_W)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .en   (state == ST_WAIT),
    .init (cfg_wait),
    .done (tmr_done)
  );

  sbf_rdy_qual #(.WD_W(WD_W)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .early    (cfg_rdy_early),
    .track    (track),
    .in_burst (in_burst),
    .rdy      (fl_rdy),
    .lim      (cfg_wdog_lim),
    .hit      (hit),
    .timeout  (timeout)
  );

  sbf_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap      (hit),
    .last     (last_word),
    .abort    (timeout),
    .din      (fl_dq),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_last  (rd_last),
    .rd_err   (rd_err)
  );

endmodule

// File: rtl/sbf_rd_ctrl_chk.sv
// Protocol checker attached to the controller.
module sbf_rd_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              fl_ce_n,
  input logic              fl_avd_n,
  input logic              fl_oe_n,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              rd_valid,
  input logic              rd_last,
  input logic              rd_err
);

  p_take_only_req_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(req_ready) |-> $past(req_valid));

  p_avd_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    !fl_avd_n |=> fl_avd_n);

  p_ce_leads_avd_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_avd_n) |-> $past(!fl_ce_n));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_avd_n) |-> $stable(fl_addr));

  p_oe_after_avd_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_oe_n) |-> $past(!fl_avd_n));

  p_oe_inside_ce_r4: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_ce_n);

  p_valid_needs_oe_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!fl_oe_n));

  p_last_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);

  p_tail_oe_first_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_last || rd_err) |-> (fl_oe_n && !fl_ce_n));

  p_tail_ce_next_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_last || rd_err) |=> (fl_ce_n && req_ready));

  p_err_no_data_r10: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> !rd_valid);

endmodule

bind sbf_rd_ctrl sbf_rd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .fl_ce_n   (fl_ce_n),
  .fl_avd_n  (fl_avd_n),
  .fl_oe_n   (fl_oe_n),
  .fl_addr   (fl_addr),
  .rd_valid  (rd_valid),
  .rd_last   (rd_last),
  .rd_err    (rd_err)
);

// File: tb/sbf_rd_ctrl_tb_top.sv
module sbf_rd_ctrl_tb_top;

  localparam int AW  = 24;
  localparam int DW  = 16;
  localparam int LW  = 8;
  localparam int WW  = 4;
  localparam int WDW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [WW-1:0] cfg_wait = WW'(6);
  logic          cfg_rdy_early = 1'b0;
  logic [WDW-1:0] cfg_wdog_lim = WDW'(15);
  logic          fl_rdy = 1'b0;
  logic [DW-1:0] fl_dq = '0;

  logic          req_ready, fl_ce_n, fl_avd_n, fl_oe_n;
  logic [AW-1:0] fl_addr;
  logic          rd_valid, rd_last, rd_err;
  logic [DW-1:0] rd_data;

  sbf_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .WAIT_W(WW), .WD_W(WDW)) dut_i (
    .clk(clk), .rst(rst), .cfg_wait(cfg_wait), .cfg_rdy_early(cfg_rdy_early),
    .cfg_wdog_lim(cfg_wdog_lim), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .fl_ce_n(fl_ce_n), .fl_avd_n(fl_avd_n),
    .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dq(fl_dq), .fl_rdy(fl_rdy),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .rd_err(rd_err)
  );

  int checks = 0;
  int errors = 0;
  int stall_mode = 0;
  int err_seen = 0;
  bit run_cmp = 1'b0;
  int cycles = 0;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'h9E37 + 32'h1234;
    return t[DW-1:0];
  endfunction

  function automatic bit rdy_pat(input int n, input int m);
    case (m)
      0:       return 1'b1;
      1:       return (n % 3) != 2;
      2:       return n < 2;
      default: return n >= 5;
    endcase
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Flash device model: honours the wait count, ready mode and stall pattern.
  int dj = -1;
  int dk = 0;
  bit d_rdy_prev = 1'b0;
  bit d_dv_last = 1'b0;
  logic [AW-1:0] d_base = '0;

  always @(negedge clk) begin
    if (!fl_avd_n) d_base = fl_addr;
    if (fl_oe_n) begin
      dj = -1; dk = 0; d_rdy_prev = 1'b0; d_dv_last = 1'b0;
      fl_rdy <= 1'b0;
      fl_dq  <= 16'hDEAD;
    end else begin
      bit r;
      bit dv;
      int st;
      if (d_dv_last) dk++;
      dj++;
      st = cfg_rdy_early ? ((cfg_wait > 0) ? int'(cfg_wait) - 1 : 0) : int'(cfg_wait);
      r  = (dj >= st) && rdy_pat(dj - st, stall_mode);
      dv = cfg_rdy_early ? d_rdy_prev : r;
      d_rdy_prev = r;
      d_dv_last  = dv;
      fl_rdy <= r;
      fl_dq  <= dv ? memf(AW'(d_base + AW'(dk))) : (16'hDEAD ^ DW'(dj));
    end
  end

  // Behavioural reference model: phase 0 idle,1 select,2 strobe,3 wait,4 burst,5 tail.
  int mph = 0, mw = 0, mleft = 0, mwd = 0, midx = 0;
  bit mr1 = 1'b0;
  logic [AW-1:0] maddr = '0;
  bit e_valid = 1'b0, e_last = 1'b0, e_err = 1'b0;
  logic [DW-1:0] e_data = '0;

  always @(posedge clk) begin
    bit hit;
    int old;
    cycles++;
    if (rst) begin
      mph = 0; mr1 = 1'b0; e_valid = 1'b0; e_last = 1'b0; e_err = 1'b0;
    end else begin
      old = mph; e_valid = 1'b0; e_last = 1'b0; e_err = 1'b0;
      case (mph)
        0: if (req_valid) begin mph = 1; maddr = req_addr; mleft = int'(req_len) + 1; midx = 0; end
        1: mph = 2;
        2: begin
          mwd = 0;
          if (cfg_wait == 0) mph = 4;
          else begin mph = 3; mw = int'(cfg_wait); end
        end
        3: if (mw <= 1) mph = 4; else mw--;
        4: begin
          hit = cfg_rdy_early ? mr1 : fl_rdy;
          if (hit) begin
            e_valid = 1'b1;
            e_data  = memf(AW'(maddr + AW'(midx)));
            midx++; mleft--; mwd = 0;
            if (mleft == 0) begin e_last = 1'b1; mph = 5; end
          end else begin
            mwd++;
            if (mwd >= int'(cfg_wdog_lim)) begin e_err = 1'b1; mph = 5; end
          end
        end
        default: mph = 0;
      endcase
      mr1 = (old == 3 || old == 4) ? fl_rdy : 1'b0;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst && run_cmp) begin
      cmp("R9 fl_ce_n", int'(fl_ce_n), int'(mph == 0));
      cmp("R3 fl_avd_n", int'(fl_avd_n), int'(mph != 2));
      cmp("R4 fl_oe_n", int'(fl_oe_n), int'(!(mph == 3 || mph == 4)));
      cmp("R2 req_ready", int'(req_ready), int'(mph == 0));
      if (cfg_rdy_early) cmp("R6 rd_valid", int'(rd_valid), int'(e_valid));
      else               cmp("R5 rd_valid", int'(rd_valid), int'(e_valid));
      cmp("R7 R8 rd_last", int'(rd_last), int'(e_last));
      cmp("R10 rd_err", int'(rd_err), int'(e_err));
      if (e_valid && rd_valid) cmp("R8 rd_data", int'(rd_data), int'(e_data));
      if (mph == 2) cmp("R3 fl_addr", int'(fl_addr), int'(maddr));
      if (rd_err) err_seen++;
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [AW-1:0] a, input int len, input int w,
                     input bit early, input int lim, input int mode);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_wait = WW'(w); cfg_rdy_early = early; cfg_wdog_lim = WDW'(lim); stall_mode = mode;
    req_addr = a; req_len = LW'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    cmp("R1 fl_ce_n", int'(fl_ce_n), 1);
    cmp("R1 fl_avd_n", int'(fl_avd_n), 1);
    cmp("R1 fl_oe_n", int'(fl_oe_n), 1);
    cmp("R1 req_ready", int'(req_ready), 1);
    cmp("R1 rd_valid", int'(rd_valid), 0);
    cmp("R1 rd_err", int'(rd_err), 0);
    rst = 1'b0;
    run_cmp = 1'b1;
    @(negedge clk);

    run(24'h000100, 3, 6, 1'b0, 15, 0);   // R5 R4 default wait of 6, aligned
    run(24'h0001F0, 7, 6, 1'b1, 15, 1);   // R6 R7 early with stalls
    run(24'hFFFFFE, 3, 0, 1'b0, 15, 1);   // R4 zero wait, R8 address wrap
    run(24'h00ABCD, 2, 1, 1'b1, 15, 3);   // R6 R7 long initial stall
    run(24'h000777, 0, 6, 1'b1, 15, 0);   // R8 single word
    run(24'h000200, 9, 4, 1'b0, 4, 2);    // R10 abort after two words
    cmp("R10 error pulses", err_seen, 1);
    run(24'h000300, 5, 2, 1'b1, 0, 2);    // R10 limit 0 acts as 1
    cmp("R10 error pulses", err_seen, 2);

    // R2: request held high across bursts; only idle cycles take it
    @(negedge clk);
    cfg_wait = WW'(3); cfg_rdy_early = 1'b0; cfg_wdog_lim = WDW'(15); stall_mode = 0;
    req_addr = 24'h000040; req_len = LW'(2); req_valid = 1'b1;
    repeat (40) @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule